// File: doc/BRIEF.md
# Asynchronous Serial Channel with Byte Register File

This block is one full-duplex asynchronous serial channel. Software talks to it through a small byte-wide register file. A byte written to the transmit holding register is moved into a shifter and sent on `txd` as a frame. A frame arriving on `rxd` is checked and then placed in the receive holding register. The frame format is set by the mode register:

- 7 or 8 data bits, least significant bit first;
- one or two stop bits;
- parity that is absent, always zero, odd or even.

Timing comes from an external rate generator. It supplies `os_tick`, which runs at sixteen times the bit rate. Every bit lasts 16 ticks on both the transmit and the receive side. The block keeps that generator's two setting registers and drives their values out on `baud_sel` and `baud_div`.

The block raises three single-cycle interrupt pulses:

- `irq_tx` when the transmitter drains completely;
- `irq_rx` when a character arrives;
- `irq_rxerr` for a character with errors, used only when the mode register routes errors away from `irq_rx`.

Reads have no latency: `rdata` follows `addr`. The side effects of a read take place on the clock edge at which `rd_en` is high.

Top module: `uart_chan`

## Requirements
- R1: After reset, these registers read 0: mode, error status and transmit status. `txd` is high and no interrupt pulses.
- R2: The byte offsets are as follows. Offset 6 keeps 4 bits and reads back zero-extended. Offsets 6 and 7 appear on `baud_sel` and `baud_div`. Offsets 1, 4 and any unused offset read 0.

  | Offset | Register |
  |---|---|
  | 0 | mode |
  | 2 | receive holding |
  | 3 | error status |
  | 4 | transmit holding (write only) |
  | 5 | transmit status |
  | 6 | rate select |
  | 7 | rate divisor |

- R3: The mode register bits are as follows. Parity codes are 00 none, 01 zero, 10 odd, 11 even.

  | Bit | Function |
  |---|---|
  | 7 | channel enable |
  | 6 | transmit enable |
  | 5 | receive enable |
  | 4:3 | parity |
  | 2 | 8 data bits (7 when clear) |
  | 1 | 2 stop bits (1 when clear) |
  | 0 | error routing |

- R4: A transmitted frame is sent in this order, each bit lasting 16 `os_tick` pulses:
  1. a low start bit;
  2. 7 or 8 data bits, LSB first;
  3. an optional parity bit;
  4. 1 or 2 high stop bits.
- R5: With odd parity the data bits plus the parity bit hold an odd number of ones. With even parity they hold an even number. With zero parity the parity bit is always 0.
- R6: The transmit status register has bit 1 set while a byte waits in the holding register and bit 0 set while the shifter sends. A write to offset 4 is ignored while a byte waits or while transmit enable or channel enable is clear.
- R7: `irq_tx` pulses for exactly one cycle when a frame ends and no byte is waiting.
- R8: The receiver accepts a start bit only if the line is still low 8 ticks after the falling edge. It samples each following bit at its middle. A 7-bit character is stored with bit 7 clear, and `irq_rx` pulses once. After each frame the receiver waits for a high line before it looks for the next start bit.
- R9: The error status register has bit 2 for a parity mismatch, bit 1 for a low first stop bit and bit 0 for overrun. Overrun means a character completed while the previous one was unread; the new character replaces it. Reading offset 3 clears all three bits.
- R10: If a character has any error and routing is 1, `irq_rx` pulses. If routing is 0, only `irq_rxerr` pulses. The two never pulse together.
- R11: While channel enable is 0, the following are all cleared and held: both state machines, both holding-full flags, the error bits and the receive holding register. While receive enable is 0, frames on `rxd` are ignored.
- R12: Reading offset 2 marks the receive holding register empty, so the next character does not raise overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x bit-rate strobe from the rate generator |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rxd | input | 1 | Serial input, asynchronous |
| txd | output | 1 | Serial output, idle high |
| baud_sel | output | CSEL_W | Rate select register value |
| baud_div | output | BAUD_W | Rate divisor register value |
| irq_tx | output | 1 | Transmitter-drained pulse |
| irq_rx | output | 1 | Character received pulse |
| irq_rxerr | output | 1 | Errored character pulse (routing 0) |

## Verification
The assertions assume that `os_tick` is never high on two adjacent cycles, so that one bit always spans many clocks. They also assume that mode changes are made only while the line is idle, because an interrupt is checked against the routing bit of the cycle before it. The bench meets both assumptions: it makes the tick every other clock and rewrites the mode only after the transmit status reads zero and any driven frame has ended. Frames on `rxd` are driven at exactly 32 clocks per bit, so the receiver's mid-bit sampling sees no drift.

// File: rtl/uart_chan_pkg.sv
`timescale 1ns/1ps
package uart_chan_pkg;
   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ZERO = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_EVEN = 2'b11
   } par_mode_e;

   // mode byte, MSB first: enable, tx enable, rx enable, parity, len8, stop2, routing
   typedef struct packed {
      logic      en;
      logic      txe;
      logic      rxe;
      par_mode_e par;
      logic      len8;
      logic      stop2;
      logic      route;
   } mode_t;

   localparam logic [2:0] OFS_MODE   = 3'd0;
   localparam logic [2:0] OFS_RXBUF  = 3'd2;
   localparam logic [2:0] OFS_ERR    = 3'd3;
   localparam logic [2:0] OFS_TXBUF  = 3'd4;
   localparam logic [2:0] OFS_TXSTAT = 3'd5;
   localparam logic [2:0] OFS_CSEL   = 3'd6;
   localparam logic [2:0] OFS_BAUD   = 3'd7;

   // parity bit value for already-masked data
   function automatic logic par_bit(input par_mode_e p, input logic [7:0] dm);
      case (p)
         PAR_ODD:  par_bit = ~^dm;
         PAR_EVEN: par_bit = ^dm;
         default:  par_bit = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/uart_chan_tx.sv
`timescale 1ns/1ps
module uart_chan_tx
   import uart_chan_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       os_tick,
   input  logic       load,
   input  logic [7:0] ld_data,
   input  logic       len8,
   input  par_mode_e  par,
   input  logic       stop2,
   output logic       busy,
   output logic       done,
   output logic       txd
);
   localparam int SUB_W   = $clog2(OVS);
   localparam int FRAME_W = 12;

   logic [FRAME_W-1:0] shreg_q, frame_c;
   logic [3:0]         left_q, nbits_c;
   logic [SUB_W-1:0]   sub_q;
   logic [7:0]         dmask;

   always_comb begin
      dmask   = len8 ? ld_data : {1'b0, ld_data[6:0]};
      frame_c = '1;
      frame_c[0] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i < 7 || len8) frame_c[1+i] = ld_data[i];
      end
      if (par != PAR_NONE) begin
         if (len8) frame_c[9] = par_bit(par, dmask);
         else      frame_c[8] = par_bit(par, dmask);
      end
      nbits_c = (len8 ? 4'd9 : 4'd8) + {3'b0, par != PAR_NONE} + (stop2 ? 4'd2 : 4'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; shreg_q <= '1; left_q <= '0; sub_q <= '0;
      end else if (clr) begin
         busy <= 1'b0; done <= 1'b0; shreg_q <= '1; left_q <= '0; sub_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy && load) begin
            busy    <= 1'b1;
            shreg_q <= frame_c;
            left_q  <= nbits_c;
            sub_q   <= '0;
         end else if (busy && os_tick) begin
            if (sub_q == SUB_W'(OVS-1)) begin
               sub_q   <= '0;
               shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
               left_q  <= left_q - 4'd1;
               if (left_q == 4'd1) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end else begin
               sub_q <= sub_q + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/uart_chan_rx.sv
`timescale 1ns/1ps
module uart_chan_rx
   import uart_chan_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       os_tick,
   input  logic       rxd,
   input  logic       len8,
   input  par_mode_e  par,
   output logic       done,
   output logic [7:0] data,
   output logic       par_err,
   output logic       frm_err
);
   localparam int SUB_W = $clog2(OVS);

   typedef enum logic [1:0] {S_WAITHI, S_IDLE, S_START, S_BITS} rx_state_e;

   rx_state_e        st_q;
   logic [SYNC_N-1:0] sync_q;
   logic             line;
   logic [SUB_W-1:0] cnt_q;
   logic [3:0]       idx_q, nsamp_c;
   logic [15:0]      bits_q, fb;
   logic [7:0]       data_c;
   logic             pbit_c, stop_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_N-2:0], rxd};
   end
   assign line = sync_q[SYNC_N-1];

   always_comb begin
      nsamp_c = (len8 ? 4'd8 : 4'd7) + {3'b0, par != PAR_NONE} + 4'd1;
      fb = bits_q;
      fb[idx_q] = line;
      data_c = len8 ? fb[7:0] : {1'b0, fb[6:0]};
      pbit_c = len8 ? fb[8] : fb[7];
      stop_c = fb[nsamp_c - 4'd1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_WAITHI; cnt_q <= '0; idx_q <= '0; bits_q <= '0;
         done <= 1'b0; data <= '0; par_err <= 1'b0; frm_err <= 1'b0;
      end else if (clr) begin
         st_q <= S_WAITHI; cnt_q <= '0; idx_q <= '0; bits_q <= '0;
         done <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st_q)
            S_WAITHI: if (line) st_q <= S_IDLE;
            S_IDLE: if (!line) begin
               st_q  <= S_START;
               cnt_q <= '0;
            end
            S_START: if (os_tick) begin
               if (cnt_q == SUB_W'(OVS/2-1)) begin
                  cnt_q <= '0;
                  idx_q <= '0;
                  st_q  <= line ? S_IDLE : S_BITS;
               end else cnt_q <= cnt_q + 1'b1;
            end
            default: if (os_tick) begin
               if (cnt_q == SUB_W'(OVS-1)) begin
                  cnt_q  <= '0;
                  bits_q <= fb;
                  idx_q  <= idx_q + 4'd1;
                  if (idx_q == nsamp_c - 4'd1) begin
                     st_q    <= S_WAITHI;
                     done    <= 1'b1;
                     data    <= data_c;
                     frm_err <= !stop_c;
                     par_err <= (par != PAR_NONE) && (pbit_c != par_bit(par, data_c));
                  end
               end else cnt_q <= cnt_q + 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_chan.sv
`timescale 1ns/1ps
module uart_chan
   import uart_chan_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int SYNC_N = 2,
   parameter int ADDR_W = 3,
   parameter int CSEL_W = 4,
   parameter int BAUD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              rxd,
   output logic              txd,
   output logic [CSEL_W-1:0] baud_sel,
   output logic [BAUD_W-1:0] baud_div,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_rxerr
);
   localparam int ERR_W = 3;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must cover offsets 0..7");
   end
   if (CSEL_W < 1 || CSEL_W > 8 || BAUD_W < 1 || BAUD_W > 8) begin : g_bad_rate
      $error("rate register widths must be 1..8");
   end

   mode_t             mode_q;
   logic [7:0]        rxbuf_q, txbuf_q, csel_rd, baud_rd;
   logic              rx_full_q, tx_full_q;
   logic [ERR_W-1:0]  err_q, new_err;
   logic [CSEL_W-1:0] csel_q;
   logic [BAUD_W-1:0] baud_q;
   logic              tx_busy, tx_done, tx_load, tx_accept;
   logic              rx_done, rx_perr, rx_ferr;
   logic [7:0]        rx_data;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [2:0] ofs);
      hit = (a == ADDR_W'(ofs));
   endfunction

   // rate registers zero-extend on readback when narrower than a byte
   if (CSEL_W < 8) begin : g_csel_pad
      assign csel_rd = {{(8-CSEL_W){1'b0}}, csel_q};
   end else begin : g_csel_full
      assign csel_rd = csel_q;
   end
   if (BAUD_W < 8) begin : g_baud_pad
      assign baud_rd = {{(8-BAUD_W){1'b0}}, baud_q};
   end else begin : g_baud_full
      assign baud_rd = baud_q;
   end

   assign tx_accept = wr_en && hit(addr, OFS_TXBUF) && mode_q.en && mode_q.txe && !tx_full_q;
   assign tx_load   = mode_q.en && tx_full_q && !tx_busy;
   assign new_err   = {rx_perr, rx_ferr, rx_full_q && !(rd_en && hit(addr, OFS_RXBUF))};

   uart_chan_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(!mode_q.en), .os_tick(os_tick),
      .load(tx_load), .ld_data(txbuf_q), .len8(mode_q.len8), .par(mode_q.par),
      .stop2(mode_q.stop2), .busy(tx_busy), .done(tx_done), .txd(txd)
   );

   uart_chan_rx #(.OVS(OVS), .SYNC_N(SYNC_N)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(!(mode_q.en && mode_q.rxe)), .os_tick(os_tick),
      .rxd(rxd), .len8(mode_q.len8), .par(mode_q.par), .done(rx_done),
      .data(rx_data), .par_err(rx_perr), .frm_err(rx_ferr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0; csel_q <= '0; baud_q <= '0;
         rxbuf_q <= '0; txbuf_q <= '0; rx_full_q <= 1'b0; tx_full_q <= 1'b0;
         err_q <= '0; irq_tx <= 1'b0; irq_rx <= 1'b0; irq_rxerr <= 1'b0;
      end else begin
         if (wr_en && hit(addr, OFS_MODE)) mode_q <= mode_t'(wdata);
         if (wr_en && hit(addr, OFS_CSEL)) csel_q <= wdata[CSEL_W-1:0];
         if (wr_en && hit(addr, OFS_BAUD)) baud_q <= wdata[BAUD_W-1:0];
         if (!mode_q.en) begin
            rxbuf_q <= '0; txbuf_q <= '0; rx_full_q <= 1'b0; tx_full_q <= 1'b0;
            err_q <= '0; irq_tx <= 1'b0; irq_rx <= 1'b0; irq_rxerr <= 1'b0;
         end else begin
            if (tx_accept) begin
               txbuf_q   <= wdata;
               tx_full_q <= 1'b1;
            end else if (tx_load) begin
               tx_full_q <= 1'b0;
            end
            irq_tx <= tx_done && !tx_full_q;
            if (rx_done) begin
               rxbuf_q   <= rx_data;
               rx_full_q <= 1'b1;
            end else if (rd_en && hit(addr, OFS_RXBUF)) begin
               rx_full_q <= 1'b0;
            end
            err_q     <= ((rd_en && hit(addr, OFS_ERR)) ? '0 : err_q) | (rx_done ? new_err : '0);
            irq_rx    <= rx_done && ((new_err == '0) || mode_q.route);
            irq_rxerr <= rx_done && (new_err != '0) && !mode_q.route;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if      (hit(addr, OFS_MODE))   rdata = mode_q;
      else if (hit(addr, OFS_RXBUF))  rdata = rxbuf_q;
      else if (hit(addr, OFS_ERR))    rdata = {5'b0, err_q};
      else if (hit(addr, OFS_TXSTAT)) rdata = {6'b0, tx_full_q, tx_busy};
      else if (hit(addr, OFS_CSEL))   rdata = csel_rd;
      else if (hit(addr, OFS_BAUD))   rdata = baud_rd;
   end

   assign baud_sel = csel_q;
   assign baud_div = baud_q;
endmodule

// File: rtl/uart_chan_sva.sv
`timescale 1ns/1ps
module uart_chan_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       route,
   input logic       txd,
   input logic       irq_tx,
   input logic       irq_rx,
   input logic       irq_rxerr,
   input logic       tx_full,
   input logic       tx_busy,
   input logic [2:0] err
);
   assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_rx, irq_rxerr}));

   assert_rxerr_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxerr |-> !$past(route));

   assert_rxerr_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxerr |-> (err != 3'b0));

   assert_txdone_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |=> !irq_tx);

   assert_txdone_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> !$past(tx_full));

   assert_disable_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!tx_full && !tx_busy && err == 3'b0 && txd));
endmodule

bind uart_chan uart_chan_sva u_sva (
   .clk(clk), .rst_n(rst_n), .en(mode_q.en), .route(mode_q.route), .txd(txd),
   .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_rxerr(irq_rxerr),
   .tx_full(tx_full_q), .tx_busy(tx_busy), .err(err_q)
);

// File: tb/uart_chan_tb_top.sv
`timescale 1ns/1ps
module uart_chan_tb_top;
   localparam int BITCLK = 32;   // 16 ticks, one tick every 2 clocks
   localparam logic [7:0] M_EN = 8'h80, M_TXE = 8'h40, M_RXE = 8'h20,
                          M_LEN8 = 8'h04, M_STOP2 = 8'h02, M_ROUTE = 8'h01;

   logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic txd, irq_tx, irq_rx, irq_rxerr;
   logic [3:0] baud_sel;
   logic [7:0] baud_div;

   int checks = 0, failures = 0;
   int n_tx = 0, n_rx = 0, n_err = 0;
   logic [11:0] exp_q[$];   // {stop2, par[1:0], len8, data}
   logic [7:0] cur_mode = '0;
   bit finished = 0;

   uart_chan dut_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
      .baud_sel(baud_sel), .baud_div(baud_div),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_rxerr(irq_rxerr)
   );

   always #5 clk = ~clk;
   always @(negedge clk) os_tick = rst_n ? ~os_tick : 1'b0;
   always @(posedge clk) begin
      if (irq_tx) n_tx++;
      if (irq_rx) n_rx++;
      if (irq_rxerr) n_err++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] m);
      cur_mode = m; reg_wr(3'd0, m);
   endtask

   task automatic send_tx(input logic [7:0] d);
      exp_q.push_back({cur_mode[1], cur_mode[4:3], cur_mode[2], d});
      reg_wr(3'd4, d);
   endtask

   task automatic wait_tx_idle();
      logic [7:0] s;
      do reg_rd(3'd5, s); while (s != 8'h00);
      repeat (4) @(negedge clk);
   endtask

   function automatic logic exp_par(input logic [1:0] p, input logic [7:0] dm);
      return (p == 2'b10) ? ~^dm : (p == 2'b11) ? ^dm : 1'b0;
   endfunction

   // drive one frame onto rxd, using the current mode's format
   task automatic send_rx(input logic [7:0] d, input bit bad_par, input bit bad_stop);
      int n;
      logic [7:0] dm;
      n  = cur_mode[2] ? 8 : 7;
      dm = cur_mode[2] ? d : {1'b0, d[6:0]};
      @(negedge clk); rxd = 1'b0; repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < n; i++) begin rxd = d[i]; repeat (BITCLK) @(negedge clk); end
      if (cur_mode[4:3] != 2'b00) begin
         rxd = exp_par(cur_mode[4:3], dm) ^ bad_par; repeat (BITCLK) @(negedge clk);
      end
      rxd = !bad_stop; repeat (BITCLK) @(negedge clk);
      rxd = 1'b1; repeat (BITCLK) @(negedge clk);
   endtask

   // scoreboard monitor on txd
   always begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
         logic [11:0] it;
         logic [7:0] d;
         int n;
         repeat (BITCLK/2) @(negedge clk);
         if (exp_q.size() == 0) begin
            chk("R6 unexpected frame on txd", 1, 0);
            repeat (BITCLK*12) @(negedge clk);
         end else begin
            it = exp_q.pop_front();
            n  = it[8] ? 8 : 7;
            chk("R4 start bit", txd, 0);
            d = '0;
            for (int i = 0; i < n; i++) begin repeat (BITCLK) @(negedge clk); d[i] = txd; end
            chk("R4 data bits", d, it[8] ? it[7:0] : {1'b0, it[6:0]});
            if (it[10:9] != 2'b00) begin
               repeat (BITCLK) @(negedge clk);
               chk("R5 parity bit", txd, exp_par(it[10:9], d));
            end
            for (int s = 0; s < (it[11] ? 2 : 1); s++) begin
               repeat (BITCLK) @(negedge clk);
               chk("R4 stop bit", txd, 1);
            end
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int t0, r0, e0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      reg_rd(3'd0, v); chk("R1 mode after reset", v, 0);
      reg_rd(3'd5, v); chk("R1 txstat after reset", v, 0);
      reg_rd(3'd3, v); chk("R1 err after reset", v, 0);
      chk("R1 txd idle", txd, 1);
      chk("R1 no irq", n_tx + n_rx + n_err, 0);

      // R2 map and rate registers
      reg_wr(3'd6, 8'hFB); reg_rd(3'd6, v); chk("R2 rate select readback", v, 8'h0B);
      chk("R2 baud_sel out", baud_sel, 4'hB);
      reg_wr(3'd7, 8'h5A); reg_rd(3'd7, v); chk("R2 rate divisor readback", v, 8'h5A);
      chk("R2 baud_div out", baud_div, 8'h5A);
      reg_rd(3'd1, v); chk("R2 unused offset", v, 0);

      // R6 write ignored with transmit disabled
      set_mode(M_EN);
      reg_rd(3'd0, v); chk("R3 mode readback", v, M_EN);
      reg_wr(3'd4, 8'h11);
      reg_rd(3'd5, v); chk("R6 txbuf write ignored when txe clear", v, 0);
      repeat (BITCLK*2) @(negedge clk);

      // R4 R6 R7 8N1 back-to-back
      set_mode(M_EN | M_TXE | M_RXE | M_LEN8 | M_ROUTE);
      t0 = n_tx;
      send_tx(8'hA5);
      repeat (4) @(negedge clk);
      reg_rd(3'd5, v); chk("R6 shifting only", v, 8'h01);
      send_tx(8'h3C);
      reg_rd(3'd5, v); chk("R6 buffer and shifter busy", v, 8'h03);
      reg_wr(3'd4, 8'h77);   // ignored: buffer full
      wait_tx_idle();
      chk("R7 one drain pulse for two frames", n_tx - t0, 1);

      // R5 parity variants
      set_mode(M_EN | M_TXE | (8'd2 << 3) | M_STOP2); send_tx(8'h5B); wait_tx_idle();
      set_mode(M_EN | M_TXE | M_LEN8 | (8'd3 << 3));  send_tx(8'h81); wait_tx_idle();
      set_mode(M_EN | M_TXE | (8'd1 << 3));           send_tx(8'h7F); wait_tx_idle();
      chk("R4 scoreboard drained", exp_q.size(), 0);

      // R8 plain receive
      set_mode(M_EN | M_RXE | M_LEN8 | M_ROUTE);
      r0 = n_rx;
      send_rx(8'h3C, 0, 0);
      reg_rd(3'd2, v); chk("R8 rx data 8N1", v, 8'h3C);
      reg_rd(3'd3, v); chk("R8 no error", v, 0);
      chk("R8 irq_rx pulse", n_rx - r0, 1);

      // R8 7-bit even parity
      set_mode(M_EN | M_RXE | (8'd3 << 3) | M_ROUTE);
      send_rx(8'hD5, 0, 0);
      reg_rd(3'd2, v); chk("R8 7-bit stored with bit7 clear", v, 8'h55);
      reg_rd(3'd3, v); chk("R5 good even parity", v, 0);

      // R9 R10 parity error, routed to irq_rx
      set_mode(M_EN | M_RXE | M_LEN8 | (8'd2 << 3) | M_ROUTE);
      r0 = n_rx; e0 = n_err;
      send_rx(8'h6E, 1, 0);
      reg_rd(3'd3, v); chk("R9 parity error bit", v, 8'h04);
      chk("R10 routed error on irq_rx", n_rx - r0, 1);
      chk("R10 no irq_rxerr when routed", n_err - e0, 0);
      reg_rd(3'd3, v); chk("R9 err cleared by read", v, 0);
      reg_rd(3'd2, v);

      // R9 R10 framing error on separate irq
      set_mode(M_EN | M_RXE | M_LEN8);
      r0 = n_rx; e0 = n_err;
      send_rx(8'h42, 0, 1);
      reg_rd(3'd3, v); chk("R9 framing error bit", v, 8'h02);
      chk("R10 irq_rxerr pulse", n_err - e0, 1);
      chk("R10 no irq_rx for error", n_rx - r0, 0);
      reg_rd(3'd2, v); chk("R9 data kept on framing error", v, 8'h42);

      // R9 overrun
      set_mode(M_EN | M_RXE | M_LEN8 | M_ROUTE);
      send_rx(8'h11, 0, 0);
      send_rx(8'h22, 0, 0);
      reg_rd(3'd3, v); chk("R9 overrun bit", v, 8'h01);
      reg_rd(3'd2, v); chk("R9 newer char replaces", v, 8'h22);

      // R12 read empties the holding register
      send_rx(8'h33, 0, 0);
      reg_rd(3'd3, v); chk("R12 no overrun after read", v, 0);

      // R8 short start glitch rejected
      r0 = n_rx;
      @(negedge clk); rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
      repeat (BITCLK*12) @(negedge clk);
      chk("R8 glitch rejected", n_rx - r0, 0);

      // R11 disable clears, receive disabled ignores
      send_rx(8'h5C, 0, 0);   // leave holding register full
      set_mode(8'h00);
      repeat (2) @(negedge clk);
      set_mode(M_EN | M_LEN8 | M_ROUTE);
      reg_rd(3'd3, v); chk("R11 err cleared by disable", v, 0);
      r0 = n_rx;
      send_rx(8'h66, 0, 0);
      chk("R11 rxe clear ignores frame", n_rx - r0, 0);
      reg_rd(3'd2, v); chk("R11 holding register cleared", v, 0);
      set_mode(M_EN | M_RXE | M_LEN8 | M_ROUTE);
      send_rx(8'h44, 0, 0);
      reg_rd(3'd3, v); chk("R11 full flag cleared by disable", v, 0);
      reg_rd(3'd2, v); chk("R11 receive after re-enable", v, 8'h44);

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule